// File: doc/BRIEF.md
# Endian-Selectable Width Down-Converter

This block sits on the read side of a FIFO that holds 36-bit long words. It hands each long word to a narrower consumer, one piece at a time. In byte mode a long word leaves as four 9-bit lanes. In word mode it leaves as two 18-bit halves. In long mode the word passes through whole. Any parity bits travel as ordinary data inside their lane.

The piece order is fixed at reset. The converter samples an endian pin and a size pin on every clock edge while reset is held low, and keeps the values from the last such edge. In big-endian order the most significant piece goes out first. In little-endian order the least significant piece goes out first.

The consumer pulls pieces with a valid/ready handshake. The converter pulls the next long word from upstream with a one-cycle fetch strobe, and it does so only once the current word has been fully consumed. The FIFO storage itself is outside this block, and so is any clock-domain crossing.

Top module: `dconv_top`

## Requirements
- R1: While `rstN` is low, `outValid` and `srcFetch` are 0 on every cycle, even when the source has data.
- R2: The endian and size settings are taken from `endianSel` and `sizeSel` at the last rising clock edge with `rstN` low. Later changes to those pins have no effect until the next reset.
- R3: Big-endian (`endianSel`=1), byte mode: the four pieces come out in the order bits 35:27, 26:18, 17:9, 8:0. Big-endian, word mode: bits 35:18 come out first, then 17:0.
- R4: Little-endian (`endianSel`=0), byte mode: the order is 8:0, 17:9, 26:18, 35:27. Little-endian, word mode: 17:0 comes out first, then 35:18.
- R5: `sizeSel` encoding: 2'b10 is bytes, 2'b01 is words, and both 2'b00 and 2'b11 select long mode. In long mode all 36 bits appear in one beat and the endian setting has no effect.
- R6: A narrow piece is placed in the low bits of `outData`. All bits above the piece are 0.
- R7: `srcFetch` is asserted only when `srcEmpty` is 0 and either no word is held, or the last piece of the held word is being consumed in that cycle. `srcData` is captured at the edge where `srcFetch` is high, and `outValid` is 1 in the cycle after that edge.
- R8: While `outValid` is 1 and `outReady` is 0, both `outValid` and `outData` stay unchanged on the next cycle.
- R9: With `outReady` held high and the source non-empty, consecutive long words follow with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the configuration pins are captured while it is low |
| endianSel | input | 1 | 1 selects big-endian order, 0 selects little-endian order |
| sizeSel | input | 2 | Output piece size (see R5) |
| srcData | input | 36 | Long word at the head of the upstream FIFO |
| srcEmpty | input | 1 | Upstream FIFO holds no word |
| srcFetch | output | 1 | Pops the head word from upstream at this edge |
| outReady | input | 1 | Consumer accepts the current piece |
| outValid | output | 1 | `outData` holds a valid piece |
| outData | output | 36 | Current piece, zero-extended |

## Verification
The checker tests on every cycle that the port-level rules hold:
- no fetch is issued from an empty source,
- no fetch is issued while a held piece is stalled,
- a fetch is always followed by valid output,
- output stays frozen under back-pressure,
- reset clears the output valid.

Only the bench scenarios can show the piece ordering for each endian and size pair, the zero upper bits, that the configuration pins are ignored after reset, and that no bubble appears between consecutive words, because each of these depends on data values carried across several beats.

// File: rtl/dconv_pkg.sv
package dconv_pkg;

  localparam int LANE_IDX_W = 2;
  localparam int LANES      = 1 << LANE_IDX_W;

  typedef enum logic [1:0] {
    UNIT_LONG = 2'd0,
    UNIT_WORD = 2'd1,
    UNIT_BYTE = 2'd2
  } unit_e;

  typedef struct packed {
    logic                  load;
    logic [LANE_IDX_W-1:0] lane;
    unit_e                 unit;
  } strobe_t;

  function automatic unit_e decodeSize(input logic [1:0] sel);
    unit_e u;
    case (sel)
      2'b10:   u = UNIT_BYTE;
      2'b01:   u = UNIT_WORD;
      default: u = UNIT_LONG;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/dconv_ctrl.sv
module dconv_ctrl
  import dconv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       endianSel,
  input  logic [1:0] sizeSel,
  input  logic       srcEmpty,
  input  logic       outReady,
  output logic       srcFetch,
  output logic       outValid,
  output strobe_t    strobes
);

  localparam int CNT_W = LANE_IDX_W;
  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(LANES - 1);
  localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(LANES / 2 - 1);

  logic             cfgBig;
  unit_e            cfgUnit;
  logic             holdValid;
  logic [CNT_W-1:0] beat;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] laneIdx;
  logic             lastBeat;
  logic             consume;
  logic             fetch;

  always_comb begin
    case (cfgUnit)
      UNIT_BYTE: lastIdx = LAST_BYTE;
      UNIT_WORD: lastIdx = LAST_WORD;
      default:   lastIdx = '0;
    endcase
  end

  assign lastBeat = (beat == lastIdx);
  assign consume  = holdValid && outReady;
  assign fetch    = rstN && !srcEmpty && (!holdValid || (consume && lastBeat));
  assign laneIdx  = cfgBig ? (lastIdx - beat) : beat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgBig    <= endianSel;
      cfgUnit   <= decodeSize(sizeSel);
      holdValid <= 1'b0;
      beat      <= '0;
    end else if (fetch) begin
      holdValid <= 1'b1;
      beat      <= '0;
    end else if (consume && lastBeat) begin
      holdValid <= 1'b0;
      beat      <= '0;
    end else if (consume) begin
      beat <= beat + 1'b1;
    end
  end

  assign srcFetch     = fetch;
  assign outValid     = holdValid;
  assign strobes.load = fetch;
  assign strobes.lane = laneIdx;
  assign strobes.unit = cfgUnit;

endmodule

// File: rtl/dconv_dp.sv
module dconv_dp
  import dconv_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [LANE_W*LANES-1:0]  srcData,
  input  strobe_t                  strobes,
  output logic [LANE_W*LANES-1:0]  outData
);

  localparam int LONG_W = LANE_W * LANES;
  localparam int WORD_W = 2 * LANE_W;
  localparam int WORDS  = LANES / 2;
  localparam int WIDX_W = LANE_IDX_W - 1;

  logic [LONG_W-1:0] hold;
  logic [LANE_W-1:0] byteLane [LANES];
  logic [WORD_W-1:0] wordLane [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN)             hold <= '0;
    else if (strobes.load) hold <= srcData;
  end

  for (genvar g = 0; g < LANES; g++) begin : gByte
    assign byteLane[g] = hold[g*LANE_W +: LANE_W];
  end

  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign wordLane[g] = hold[g*WORD_W +: WORD_W];
  end

  always_comb begin
    outData = '0;
    case (strobes.unit)
      UNIT_BYTE: outData[LANE_W-1:0] = byteLane[strobes.lane];
      UNIT_WORD: outData[WORD_W-1:0] = wordLane[strobes.lane[WIDX_W-1:0]];
      default:   outData = hold;
    endcase
  end

endmodule

// File: rtl/dconv_top.sv
module dconv_top
  import dconv_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LONG_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endianSel,
  input  logic [1:0]        sizeSel,
  input  logic [LONG_W-1:0] srcData,
  input  logic              srcEmpty,
  output logic              srcFetch,
  input  logic              outReady,
  output logic              outValid,
  output logic [LONG_W-1:0] outData
);

  strobe_t ctrlStrobes;

  dconv_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .endianSel(endianSel),
    .sizeSel  (sizeSel),
    .srcEmpty (srcEmpty),
    .outReady (outReady),
    .srcFetch (srcFetch),
    .outValid (outValid),
    .strobes  (ctrlStrobes)
  );

  dconv_dp #(.LANE_W(LANE_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .srcData(srcData),
    .strobes(ctrlStrobes),
    .outData(outData)
  );

endmodule

// File: rtl/dconv_checker.sv
module dconv_checker #(
  parameter int LONG_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              srcEmpty,
  input logic              srcFetch,
  input logic              outReady,
  input logic              outValid,
  input logic [LONG_W-1:0] outData
);

  // R1: reset clears the output valid
  a_r1_reset_clears_valid: assert property (@(posedge clk)
    !rstN |=> !outValid);

  // R7: never pop an empty source
  a_r7_no_fetch_empty: assert property (@(posedge clk) disable iff (!rstN)
    srcFetch |-> !srcEmpty);

  // R7: never pop while a held piece is stalled
  a_r7_no_fetch_stalled: assert property (@(posedge clk) disable iff (!rstN)
    srcFetch |-> (!outValid || outReady));

  // R7: a fetched word is presented on the next cycle
  a_r7_valid_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    srcFetch |=> outValid);

  // R8: back-pressure freezes the output
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

bind dconv_top dconv_checker #(.LONG_W(LONG_W)) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .srcEmpty(srcEmpty),
  .srcFetch(srcFetch),
  .outReady(outReady),
  .outValid(outValid),
  .outData (outData)
);

// File: tb/tb_dconv_top.sv
module tb_dconv_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        big;
    logic [1:0]  size;
    logic [35:0] data;
    logic [35:0] expFirst;
  } vec_t;

  localparam logic [35:0] PAT = {9'h1A3, 9'h0B4, 9'h1C5, 9'h0D6};

  localparam vec_t VECS [6] = '{
    '{1'b1, 2'b10, PAT, {27'd0, 9'h1A3}},
    '{1'b0, 2'b10, PAT, {27'd0, 9'h0D6}},
    '{1'b1, 2'b01, PAT, {18'd0, 9'h1A3, 9'h0B4}},
    '{1'b0, 2'b01, PAT, {18'd0, 9'h1C5, 9'h0D6}},
    '{1'b1, 2'b00, PAT, PAT},
    '{1'b0, 2'b11, PAT, PAT}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        endianSel = 1'b0;
  logic [1:0]  sizeSel = 2'b00;
  logic [35:0] srcData;
  logic        srcEmpty;
  logic        srcFetch;
  logic        outReady = 1'b0;
  logic        outValid;
  logic [35:0] outData;

  logic [35:0] fifoMem [16];
  logic [3:0]  wrPtr = '0;
  logic [3:0]  rdPtr = '0;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign srcEmpty = (wrPtr == rdPtr);
  assign srcData  = fifoMem[rdPtr];

  always @(posedge clk) if (srcFetch) rdPtr <= rdPtr + 1'b1;

  dconv_top dut (
    .clk(clk), .rstN(rstN), .endianSel(endianSel), .sizeSel(sizeSel),
    .srcData(srcData), .srcEmpty(srcEmpty), .srcFetch(srcFetch),
    .outReady(outReady), .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [35:0] d);
    fifoMem[wrPtr] = d;
    wrPtr = wrPtr + 1'b1;
  endtask

  function automatic int beatsOf(input logic [1:0] s);
    return (s == 2'b10) ? 4 : (s == 2'b01) ? 2 : 1;
  endfunction

  function automatic logic [35:0] expBeat(input logic big, input logic [1:0] s,
                                          input logic [35:0] d, input int k);
    int n;
    int idx;
    n = beatsOf(s);
    idx = big ? (n - 1 - k) : k;
    if (n == 4) return {27'd0, d[idx*9 +: 9]};
    if (n == 2) return {18'd0, d[idx*18 +: 18]};
    return d;
  endfunction

  task automatic doReset(input logic big, input logic [1:0] s);
    @(negedge clk);
    rstN = 1'b0;
    outReady = 1'b0;
    endianSel = big;
    sizeSel = s;
    wrPtr = rdPtr;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 36'd0, 36'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state with data waiting upstream
    doReset(1'b1, 2'b10);
    push(PAT);
    #1;
    check(outValid == 1'b0, "R1 outValid in reset", {35'd0, outValid}, 36'd0);
    check(srcFetch == 1'b0, "R1 srcFetch in reset", {35'd0, srcFetch}, 36'd0);
    @(negedge clk); #1;
    check(outValid == 1'b0 && srcFetch == 1'b0, "R1 second reset cycle",
          {34'd0, outValid, srcFetch}, 36'd0);

    // Table walk: R3 R4 R5 R6 R9
    for (int v = 0; v < 6; v++) begin
      int n;
      doReset(VECS[v].big, VECS[v].size);
      push(VECS[v].data);
      push(~VECS[v].data);
      n = beatsOf(VECS[v].size);
      outReady = 1'b1;
      rstN = 1'b1;
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < n; k++) begin
          logic [35:0] d;
          logic [35:0] e;
          d = (w == 0) ? VECS[v].data : ~VECS[v].data;
          e = expBeat(VECS[v].big, VECS[v].size, d, k);
          @(negedge clk); #1;
          if (w == 0 && k == 0)
            check(outData === VECS[v].expFirst, "R3/R4/R5 first piece", outData, VECS[v].expFirst);
          check(outValid && outData === e, "R3 R4 R5 R6 R9 piece order", outData, e);
        end
      end
      @(negedge clk); #1;
      check(outValid == 1'b0, "R7 drained", {35'd0, outValid}, 36'd0);
      outReady = 1'b0;
    end

    // R2: pin changes after reset are ignored
    doReset(1'b1, 2'b10);
    push(PAT);
    rstN = 1'b1;
    endianSel = 1'b0;
    sizeSel = 2'b00;
    outReady = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic [35:0] e;
      e = expBeat(1'b1, 2'b10, PAT, k);
      @(negedge clk); #1;
      check(outValid && outData === e, "R2 config held", outData, e);
    end
    outReady = 1'b0;

    // R8 and R7: stall, and no mid-word fetch
    doReset(1'b0, 2'b01);
    push(PAT);
    push(~PAT);
    rstN = 1'b1;
    @(negedge clk); #1;
    for (int c = 0; c < 3; c++) begin
      check(outValid && outData === {18'd0, 9'h1C5, 9'h0D6}, "R8 stalled piece",
            outData, {18'd0, 9'h1C5, 9'h0D6});
      check(srcFetch == 1'b0, "R7 no fetch while stalled", {35'd0, srcFetch}, 36'd0);
      @(negedge clk); #1;
    end
    outReady = 1'b1;
    #1;
    check(srcFetch == 1'b0, "R7 no fetch on non-last piece", {35'd0, srcFetch}, 36'd0);
    @(negedge clk); #1;
    check(outData === {18'd0, 9'h1A3, 9'h0B4}, "R4 second half", outData, {18'd0, 9'h1A3, 9'h0B4});
    check(srcFetch == 1'b1, "R9 fetch on last piece", {35'd0, srcFetch}, 36'd1);
    @(negedge clk); #1;
    check(outValid && outData === {18'd0, ~{9'h1C5, 9'h0D6}}, "R9 next word no bubble",
          outData, {18'd0, ~{9'h1C5, 9'h0D6}});
    @(negedge clk); #1;
    @(negedge clk); #1;
    check(outValid == 1'b0, "R7 empty source idle", {35'd0, outValid}, 36'd0);
    check(srcFetch == 1'b0, "R7 no fetch when empty", {35'd0, srcFetch}, 36'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule